// File: doc/BRIEF.md
# Interrupt Distributor Control Register Group

This block holds the global control, type and identification registers of a multi-processor interrupt distributor. A guest-side 32-bit register port and a host-side 32-bit register port reach the same three words. The guest port is how software running on the processors programs and reads the block. The host port is used by the managing environment, for example to save and restore state. Every access is answered exactly one cycle after its request.

The control word carries the global enable. When the enable turns on, the block sends a one-cycle wake pulse to every active processor. The type word reports how many interrupt lines exist and how many processors are active. The identification word contains a revision field that starts at a parameterised value.

Only the host port may change the revision, and only to a supported value. Once it does, a sticky unlock flag opens host writes to the per-interrupt group storage. That storage lives outside this block. The block forwards the accepted group writes to it, and drops them while the flag is still clear.

Top module: `dctl_top`

## Requirements
- R1: After reset the enable is 0, no acknowledge, error or wake output is asserted, the revision equals REV_RESET and host group writes are locked.
- R2: Each request is acknowledged in the following cycle. Read data then comes from the register selected by the word index: 0 control, 1 type, 2 identification. Index 3 reads as zero, and writes return zero data.
- R3: A control write from either port stores write-data bit 0 as the enable, and the control word reads back the enable in bit 0 with all other bits zero. If both ports write control in the same cycle, the host value wins.
- R4: A change of the enable from 0 to 1 drives wake_o for exactly one cycle, together with the acknowledge. Bit i is set for each processor i below active_cpus. Writing 1 while the enable is already 1 gives no pulse.
- R5: The type word holds the interrupt count field in bits [4:0] and the active processor field in bits [7:5], with all other bits zero. The count field is (NUM_SHARED+32)/32-1 and the processor field is active_cpus-1.
- R6: Guest writes to the type and identification words change nothing that either word reads back.
- R7: The identification word holds PRODUCT_ID in bits [31:24], zero in bits [23:16], the revision in bits [15:12] and IMPL_ID in bits [11:0].
- R8: A host write to the identification word that differs from its current value in any bit outside [15:12] is rejected. The error flag is raised and no state changes.
- R9: A host identification write with all other bits matching is accepted only if the new revision is 2 or 3. Acceptance stores the revision and sets the unlock flag, which stays set until reset. Any other revision is rejected with the error flag.
- R10: A host write with h_grp set is acknowledged without error. While locked it is dropped. Once unlocked it appears one cycle later as a single grp_wr_o pulse carrying its address and data.
- R11: h_err is asserted only together with h_ack and only in answer to a host identification write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active_cpus | input | CPU_W | Number of active processors (1..MAX_CPUS) |
| g_req | input | 1 | Guest access request |
| g_we | input | 1 | Guest write (1) or read (0) |
| g_addr | input | 2 | Guest word index (byte address bits 3:2) |
| g_wdata | input | 32 | Guest write data |
| g_ack | output | 1 | Guest acknowledge, one cycle after request |
| g_rdata | output | 32 | Guest read data, valid with g_ack |
| h_req | input | 1 | Host access request |
| h_we | input | 1 | Host write (1) or read (0) |
| h_grp | input | 1 | Host access targets the group storage region |
| h_addr | input | HAW | Host word address; bits [1:0] select the register |
| h_wdata | input | 32 | Host write data |
| h_ack | output | 1 | Host acknowledge, one cycle after request |
| h_rdata | output | 32 | Host read data, valid with h_ack |
| h_err | output | 1 | Host write rejected, valid with h_ack |
| grp_wr_o | output | 1 | Forwarded group write strobe |
| grp_addr_o | output | HAW | Forwarded group write address |
| grp_data_o | output | 32 | Forwarded group write data |
| wake_o | output | MAX_CPUS | Per-processor wake pulse |

## Verification
Most corrupt internal states in this block show up on the first read that follows them. A wrong revision or enable appears in the read data one cycle after the request. A wrongly cleared unlock flag appears as a missing grp_wr_o pulse on the next host group write. Wake logic that tracks the wrong previous enable value shows up in the acknowledge cycle of a control write: either a pulse is missing on a real 0-to-1 change, or a pulse appears on a repeated 1. Rejection errors show directly on h_err in the acknowledge cycle, and a read right afterwards confirms that the revision stayed put.

// File: rtl/dctl_pkg.sv
package dctl_pkg;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_TYPE  = 2'd1,
        REG_IDENT = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_e;

    localparam int REV_LSB = 12;
    localparam int REV_W   = 4;
    localparam logic [31:0] REV_MASK = 32'h0000_F000;

    function automatic logic rev_supported(input logic [REV_W-1:0] rev);
        return (rev == 4'd2) || (rev == 4'd3);
    endfunction

endpackage

// File: rtl/dctl_ctrl.sv
module dctl_ctrl #(
    parameter int MAX_CPUS = 8,
    parameter int CPU_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                g_wr,
    input  logic                g_en_bit,
    input  logic                h_wr,
    input  logic                h_en_bit,
    input  logic [CPU_W-1:0]    active_cpus,
    output logic                enable_o,
    output logic [MAX_CPUS-1:0] wake_o
);

    typedef struct packed {
        logic                en;
        logic [MAX_CPUS-1:0] wake;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic [MAX_CPUS-1:0] cpu_mask;

    for (genvar gi = 0; gi < MAX_CPUS; gi++) begin : g_mask
        assign cpu_mask[gi] = (gi < int'(active_cpus));
    end

    always_comb begin
        st_d      = st_q;
        st_d.wake = '0;
        if (h_wr) begin
            st_d.en = h_en_bit;
        end else if (g_wr) begin
            st_d.en = g_en_bit;
        end
        if (st_d.en && !st_q.en) begin
            st_d.wake = cpu_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign enable_o = st_q.en;
    assign wake_o   = st_q.wake;

endmodule

// File: rtl/dctl_ident.sv
module dctl_ident
    import dctl_pkg::*;
#(
    parameter logic [7:0]       PRODUCT_ID = 8'h4B,
    parameter logic [11:0]      IMPL_ID    = 12'h43B,
    parameter logic [REV_W-1:0] REV_RESET  = 4'd1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        h_id_wr,
    input  logic [31:0] h_wdata,
    output logic [31:0] ident_o,
    output logic        unlocked_o,
    output logic        reject_o
);

    typedef struct packed {
        logic [REV_W-1:0] rev;
        logic             unlocked;
    } id_st_t;

    id_st_t st_d, st_q;
    logic [31:0]      other_diff;
    logic [REV_W-1:0] new_rev;
    logic             accept;

    assign ident_o    = {PRODUCT_ID, 8'h00, st_q.rev, IMPL_ID};
    assign other_diff = (h_wdata ^ ident_o) & ~REV_MASK;
    assign new_rev    = h_wdata[REV_LSB +: REV_W];

    always_comb begin
        st_d     = st_q;
        accept   = h_id_wr && (other_diff == '0) && rev_supported(new_rev);
        reject_o = h_id_wr && !accept;
        if (accept) begin
            st_d.rev      = new_rev;
            st_d.unlocked = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rev      <= REV_RESET;
            st_q.unlocked <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign unlocked_o = st_q.unlocked;

endmodule

// File: rtl/dctl_type.sv
module dctl_type #(
    parameter int NUM_SHARED = 96,
    parameter int CPU_W      = 4
) (
    input  logic [CPU_W-1:0] active_cpus,
    output logic [31:0]      type_o
);

    localparam int TOTAL_LINES = NUM_SHARED + 32;
    localparam int LINES_FIELD = TOTAL_LINES / 32 - 1;

    logic [CPU_W-1:0] cpus_m1;

    always_comb begin
        cpus_m1 = active_cpus - CPU_W'(1);
        type_o  = {24'h0, 3'(cpus_m1), 5'(LINES_FIELD)};
    end

endmodule

// File: rtl/dctl_top.sv
module dctl_top
    import dctl_pkg::*;
#(
    parameter int          NUM_SHARED = 96,
    parameter int          MAX_CPUS   = 8,
    parameter int          HAW        = 10,
    parameter logic [7:0]  PRODUCT_ID = 8'h4B,
    parameter logic [11:0] IMPL_ID    = 12'h43B,
    parameter logic [3:0]  REV_RESET  = 4'd1,
    localparam int         CPU_W      = $clog2(MAX_CPUS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CPU_W-1:0]    active_cpus,
    input  logic                g_req,
    input  logic                g_we,
    input  logic [1:0]          g_addr,
    input  logic [31:0]         g_wdata,
    output logic                g_ack,
    output logic [31:0]         g_rdata,
    input  logic                h_req,
    input  logic                h_we,
    input  logic                h_grp,
    input  logic [HAW-1:0]      h_addr,
    input  logic [31:0]         h_wdata,
    output logic                h_ack,
    output logic [31:0]         h_rdata,
    output logic                h_err,
    output logic                grp_wr_o,
    output logic [HAW-1:0]      grp_addr_o,
    output logic [31:0]         grp_data_o,
    output logic [MAX_CPUS-1:0] wake_o
);

    typedef struct packed {
        logic           g_ack;
        logic [31:0]    g_rdata;
        logic           h_ack;
        logic [31:0]    h_rdata;
        logic           h_err;
        logic           grp_wr;
        logic [HAW-1:0] grp_addr;
        logic [31:0]    grp_data;
    } resp_t;

    resp_t rsp_d, rsp_q;

    reg_sel_e g_sel, h_sel;
    logic     h_reg_acc;
    logic     g_ctrl_wr, h_ctrl_wr, h_id_wr;
    logic     enable, unlocked, id_reject;
    logic [31:0] type_word, ident_word;
    logic [31:0] g_word, h_word;

    wire unused_gdata = ^g_wdata[31:1];

    assign g_sel     = reg_sel_e'(g_addr);
    assign h_sel     = reg_sel_e'(h_addr[1:0]);
    assign h_reg_acc = h_req && !h_grp;
    assign g_ctrl_wr = g_req && g_we && (g_sel == REG_CTRL);
    assign h_ctrl_wr = h_reg_acc && h_we && (h_sel == REG_CTRL);
    assign h_id_wr   = h_reg_acc && h_we && (h_sel == REG_IDENT);

    dctl_ctrl #(
        .MAX_CPUS (MAX_CPUS),
        .CPU_W    (CPU_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .g_wr        (g_ctrl_wr),
        .g_en_bit    (g_wdata[0]),
        .h_wr        (h_ctrl_wr),
        .h_en_bit    (h_wdata[0]),
        .active_cpus (active_cpus),
        .enable_o    (enable),
        .wake_o      (wake_o)
    );

    dctl_ident #(
        .PRODUCT_ID (PRODUCT_ID),
        .IMPL_ID    (IMPL_ID),
        .REV_RESET  (REV_RESET)
    ) u_ident (
        .clk        (clk),
        .rst_n      (rst_n),
        .h_id_wr    (h_id_wr),
        .h_wdata    (h_wdata),
        .ident_o    (ident_word),
        .unlocked_o (unlocked),
        .reject_o   (id_reject)
    );

    dctl_type #(
        .NUM_SHARED (NUM_SHARED),
        .CPU_W      (CPU_W)
    ) u_type (
        .active_cpus (active_cpus),
        .type_o      (type_word)
    );

    function automatic logic [31:0] pick_word(input reg_sel_e sel, input logic en,
                                              input logic [31:0] tw, input logic [31:0] iw);
        case (sel)
            REG_CTRL:  return {31'h0, en};
            REG_TYPE:  return tw;
            REG_IDENT: return iw;
            default:   return 32'h0;
        endcase
    endfunction

    always_comb begin
        g_word = pick_word(g_sel, enable, type_word, ident_word);
        h_word = pick_word(h_sel, enable, type_word, ident_word);

        rsp_d          = rsp_q;
        rsp_d.g_ack    = g_req;
        rsp_d.g_rdata  = (g_req && !g_we) ? g_word : 32'h0;
        rsp_d.h_ack    = h_req;
        rsp_d.h_rdata  = (h_reg_acc && !h_we) ? h_word : 32'h0;
        rsp_d.h_err    = id_reject;
        rsp_d.grp_wr   = h_req && h_we && h_grp && unlocked;
        if (rsp_d.grp_wr) begin
            rsp_d.grp_addr = h_addr;
            rsp_d.grp_data = h_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign g_ack      = rsp_q.g_ack;
    assign g_rdata    = rsp_q.g_rdata;
    assign h_ack      = rsp_q.h_ack;
    assign h_rdata    = rsp_q.h_rdata;
    assign h_err      = rsp_q.h_err;
    assign grp_wr_o   = rsp_q.grp_wr;
    assign grp_addr_o = rsp_q.grp_addr;
    assign grp_data_o = rsp_q.grp_data;

endmodule

// File: rtl/dctl_chk.sv
module dctl_chk #(
    parameter int MAX_CPUS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                g_req,
    input logic                g_ack,
    input logic                h_req,
    input logic                h_we,
    input logic                h_grp,
    input logic [1:0]          h_word,
    input logic                h_ack,
    input logic                h_err,
    input logic                grp_wr_o,
    input logic [MAX_CPUS-1:0] wake_o,
    input logic                unlocked
);

    // R2
    g_ack_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        g_req |=> g_ack);

    // R2
    g_ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        g_ack |-> $past(g_req));

    // R11
    err_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_err |-> h_ack);

    // R8
    err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_err |-> $past(h_req && h_we && !h_grp && (h_word == 2'd2)));

    // R4
    wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_o != '0) |=> (wake_o == '0));

    // R9
    unlock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked |=> unlocked);

    // R10
    grp_fwd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grp_wr_o |-> $past(h_req && h_we && h_grp && unlocked));

    // R10
    grp_locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_req && h_we && h_grp && !unlocked) |=> !grp_wr_o);

endmodule

bind dctl_top dctl_chk #(
    .MAX_CPUS (MAX_CPUS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .g_req    (g_req),
    .g_ack    (g_ack),
    .h_req    (h_req),
    .h_we     (h_we),
    .h_grp    (h_grp),
    .h_word   (h_addr[1:0]),
    .h_ack    (h_ack),
    .h_err    (h_err),
    .grp_wr_o (grp_wr_o),
    .wake_o   (wake_o),
    .unlocked (unlocked)
);

// File: tb/dctl_top_tb.sv
module dctl_top_tb;

    localparam int          NUM_SHARED = 96;
    localparam int          MAX_CPUS   = 8;
    localparam int          HAW        = 10;
    localparam int          CPU_W      = 4;
    localparam logic [7:0]  PROD       = 8'h4B;
    localparam logic [11:0] IMPL       = 12'h43B;
    localparam logic [3:0]  REV0       = 4'd1;
    localparam logic [4:0]  LINES_F    = 5'((NUM_SHARED + 32) / 32 - 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CPU_W-1:0] active_cpus = 4'd4;
    logic g_req = 0, g_we = 0;
    logic [1:0] g_addr = '0;
    logic [31:0] g_wdata = '0;
    logic g_ack;
    logic [31:0] g_rdata;
    logic h_req = 0, h_we = 0, h_grp = 0;
    logic [HAW-1:0] h_addr = '0;
    logic [31:0] h_wdata = '0;
    logic h_ack, h_err, grp_wr_o;
    logic [31:0] h_rdata, grp_data_o;
    logic [HAW-1:0] grp_addr_o;
    logic [MAX_CPUS-1:0] wake_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic s_ack, s_err, s_grp;
    logic [31:0] s_rd;
    logic [MAX_CPUS-1:0] s_wake;

    always #4 clk = ~clk;

    dctl_top #(
        .NUM_SHARED (NUM_SHARED), .MAX_CPUS (MAX_CPUS), .HAW (HAW),
        .PRODUCT_ID (PROD), .IMPL_ID (IMPL), .REV_RESET (REV0)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .active_cpus (active_cpus),
        .g_req (g_req), .g_we (g_we), .g_addr (g_addr), .g_wdata (g_wdata),
        .g_ack (g_ack), .g_rdata (g_rdata),
        .h_req (h_req), .h_we (h_we), .h_grp (h_grp), .h_addr (h_addr),
        .h_wdata (h_wdata), .h_ack (h_ack), .h_rdata (h_rdata), .h_err (h_err),
        .grp_wr_o (grp_wr_o), .grp_addr_o (grp_addr_o), .grp_data_o (grp_data_o),
        .wake_o (wake_o)
    );

    function automatic logic [31:0] id_word(input logic [3:0] rev);
        return {PROD, 8'h00, rev, IMPL};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic guest_op(input logic we, input logic [1:0] a, input logic [31:0] d);
        g_req = 1; g_we = we; g_addr = a; g_wdata = d;
        @(posedge clk); @(negedge clk);
        s_ack = g_ack; s_rd = g_rdata; s_wake = wake_o;
        g_req = 0; g_we = 0;
    endtask

    task automatic host_op(input logic grp, input logic we, input logic [HAW-1:0] a,
                           input logic [31:0] d);
        h_req = 1; h_we = we; h_grp = grp; h_addr = a; h_wdata = d;
        @(posedge clk); @(negedge clk);
        s_ack = h_ack; s_rd = h_rdata; s_err = h_err; s_grp = grp_wr_o; s_wake = wake_o;
        h_req = 0; h_we = 0; h_grp = 0;
    endtask

    task automatic t_reset();
        check("R1 g_ack idle", 32'(g_ack), 0);
        check("R1 h_ack idle", 32'(h_ack), 0);
        check("R1 h_err idle", 32'(h_err), 0);
        check("R1 wake idle", 32'(wake_o), 0);
        guest_op(0, 2'd0, 0);
        check("R1 enable reset", s_rd, 0);
        check("R2 ack on read", 32'(s_ack), 1);
        guest_op(0, 2'd2, 0);
        check("R7 ident reset rev", s_rd, id_word(REV0));
        host_op(1, 1, 10'h155, 32'hCAFE0001);
        check("R1 locked group write dropped", 32'(s_grp), 0);
    endtask

    task automatic t_type();
        guest_op(0, 2'd1, 0);
        check("R5 type 4 cpus", s_rd, {24'h0, 3'd3, LINES_F});
        active_cpus = 4'd1;
        guest_op(0, 2'd1, 0);
        check("R5 type 1 cpu", s_rd, {24'h0, 3'd0, LINES_F});
        active_cpus = 4'd8;
        host_op(0, 0, 10'h001, 0);
        check("R5 type 8 cpus host", s_rd, {24'h0, 3'd7, LINES_F});
        guest_op(0, 2'd3, 0);
        check("R2 index 3 zero", s_rd, 0);
        active_cpus = 4'd4;
    endtask

    task automatic t_enable();
        guest_op(1, 2'd0, 32'h1);
        check("R2 write ack", 32'(s_ack), 1);
        check("R2 write data zero", s_rd, 0);
        check("R4 wake on rise", 32'(s_wake), 32'h0F);
        @(negedge clk);
        check("R4 wake one cycle", 32'(wake_o), 0);
        guest_op(0, 2'd0, 0);
        check("R3 enable read", s_rd, 1);
        guest_op(1, 2'd0, 32'hFFFF_FFFF);
        check("R4 no wake when already on", 32'(s_wake), 0);
        guest_op(0, 2'd0, 0);
        check("R3 other bits zero", s_rd, 1);
        host_op(0, 1, 10'h000, 32'hFFFF_FFFE);
        host_op(0, 0, 10'h000, 0);
        check("R3 host clears enable", s_rd, 0);
        active_cpus = 4'd6;
        fork
            guest_op(1, 2'd0, 32'h0);
            host_op(0, 1, 10'h000, 32'h1);
        join
        check("R4 wake six cpus", 32'(s_wake), 32'h3F);
        guest_op(0, 2'd0, 0);
        check("R3 host wins collision", s_rd, 1);
        active_cpus = 4'd4;
    endtask

    task automatic t_guest_ro();
        guest_op(1, 2'd1, 32'h0);
        guest_op(1, 2'd2, id_word(4'd3));
        guest_op(0, 2'd1, 0);
        check("R6 type unchanged", s_rd, {24'h0, 3'd3, LINES_F});
        guest_op(0, 2'd2, 0);
        check("R6 ident unchanged", s_rd, id_word(REV0));
        host_op(1, 1, 10'h200, 32'h1);
        check("R6 still locked", 32'(s_grp), 0);
    endtask

    task automatic t_host_id();
        host_op(1, 1, 10'h3F0, 32'h1234);
        check("R10 locked ack", 32'(s_ack), 1);
        check("R10 locked no err", 32'(s_err), 0);
        check("R10 locked dropped", 32'(s_grp), 0);
        host_op(0, 1, 10'h002, id_word(4'd2) ^ 32'h0100_0000);
        check("R8 product mismatch err", 32'(s_err), 1);
        host_op(0, 1, 10'h002, id_word(4'd2) | 32'h0001_0000);
        check("R8 reserved mismatch err", 32'(s_err), 1);
        host_op(0, 0, 10'h002, 0);
        check("R8 ident unchanged", s_rd, id_word(REV0));
        check("R11 no err on read", 32'(s_err), 0);
        host_op(0, 1, 10'h002, id_word(4'd5));
        check("R9 rev 5 rejected", 32'(s_err), 1);
        host_op(1, 1, 10'h011, 32'h77);
        check("R9 still locked after reject", 32'(s_grp), 0);
        host_op(0, 1, 10'h002, id_word(4'd3));
        check("R9 rev 3 accepted", 32'(s_err), 0);
        host_op(0, 0, 10'h002, 0);
        check("R9 rev 3 stored", s_rd, id_word(4'd3));
        host_op(1, 1, 10'h2A5, 32'hDEAD_BEEF);
        check("R10 forwarded strobe", 32'(s_grp), 1);
        check("R10 forwarded addr", 32'(grp_addr_o), 32'h2A5);
        check("R10 forwarded data", grp_data_o, 32'hDEAD_BEEF);
        check("R10 no err", 32'(s_err), 0);
        @(negedge clk);
        check("R10 strobe one cycle", 32'(grp_wr_o), 0);
        host_op(0, 1, 10'h002, id_word(4'd2));
        check("R9 rev 2 accepted", 32'(s_err), 0);
        host_op(0, 1, 10'h002, id_word(4'd0));
        check("R9 rev 0 rejected", 32'(s_err), 1);
        guest_op(0, 2'd2, 0);
        check("R9 rev 2 kept", s_rd, id_word(4'd2));
        host_op(1, 1, 10'h004, 32'h5);
        check("R9 unlock sticky", 32'(s_grp), 1);
        host_op(0, 1, 10'h001, 32'h0);
        check("R11 no err on type write", 32'(s_err), 0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_type();
        t_enable();
        t_guest_ro();
        t_host_id();
        done = 1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule